// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Transfer Engine

This block is one channel of a data mover. Software loads a source address, a destination address and a byte count, then writes a control word. The control word carries the element size of each side, whether each address steps, the run mode, an interrupt enable, a link-channel number and two ways to start: a self-clearing software go bit, and an enable that lets an external peripheral request line trigger the channel.

Each transfer is one read from the source followed by one write to the destination on a single-beat bus with a ready handshake. Both accesses use the wider of the two element sizes. Before any bus access the channel checks its configuration. A bad configuration raises an error flag and the channel never becomes busy. In cycle-steal mode each request moves one unit. In continuous mode one request runs until the count is exhausted.

Top module: `dma_xfer_channel`

## Requirements
- R1: A request exists when the go bit is set, or when the hardware enable is set and `preq` is high. While the enable is clear, `preq` has no effect.
- R2: On a valid request the channel is busy from the next clock edge. The go bit reads 0 from that same edge.
- R3: Size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, and 11 is reserved. The configuration error flag is set, and the bus is never driven, when any of these holds: a size is reserved; the source address is not aligned to the source size; the destination address is not aligned to the destination size; the count is zero; the count is not a multiple of the unit size; or the link field equals the channel's own number `CH_ID`.
- R4: A transfer reads the source address and then writes the destination address with the data read. Both accesses use the larger of the two sizes, shown on `bus_size` in the R3 code. An access stays on the bus unchanged until `bus_ready`.
- R5: After each completed write, each address advances by its own side's byte size, but only when that side's step enable is set.
- R6: After each write the count drops by the unit size. When it reaches zero, `stat_done` sets, `stat_busy` clears and the hardware enable clears.
- R7: In cycle-steal mode each request moves exactly one unit, and then the channel returns to idle.
- R8: In continuous mode one request moves units back to back until the count reaches zero.
- R9: A one-cycle pulse on `clr_status` clears both the done flag and the error flag.
- R10: Writes to the address, count and control registers are ignored while the channel is busy.
- R11: `irq` is high while the interrupt enable is set and either the done flag or the error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_go | input | 1 | Software go bit |
| ctl_hw_en | input | 1 | Peripheral request enable |
| ctl_src_size | input | 2 | Source element size code |
| ctl_dst_size | input | 2 | Destination element size code |
| ctl_src_inc | input | 1 | Source address step enable |
| ctl_dst_inc | input | 1 | Destination address step enable |
| ctl_burst | input | 1 | 1 = continuous, 0 = cycle-steal |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_link | input | 2 | Link channel number |
| src_we | input | 1 | Source address write strobe |
| src_wdata | input | AW | Source address value |
| dst_we | input | 1 | Destination address write strobe |
| dst_wdata | input | AW | Destination address value |
| cnt_we | input | 1 | Byte count write strobe |
| cnt_wdata | input | CW | Byte count value |
| clr_status | input | 1 | Clear done and error flags |
| preq | input | 1 | Peripheral request line |
| bus_valid | output | 1 | Bus access active |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| go_out | output | 1 | Current go bit |
| hw_en_out | output | 1 | Current hardware enable |
| src_out | output | AW | Current source address |
| dst_out | output | AW | Current destination address |
| cnt_out | output | CW | Remaining byte count |
| stat_done | output | 1 | Done flag |
| stat_busy | output | 1 | Busy flag |
| stat_cerr | output | 1 | Configuration error flag |
| irq | output | 1 | Interrupt |

## Verification
The assertions check these rules on every cycle:
- the go bit is already clear when busy rises;
- no bus access is in flight when the error flag rises;
- a stalled access holds its address and direction;
- every completed read is followed at once by a write;
- done only rises with a zero count, busy clear and the hardware enable clear;
- the size and mode fields stay frozen while busy.

Only the bench scenarios can show the rest:
- the data that lands in memory;
- the end addresses under each mix of sizes and step enables;
- the number of bus beats in each mode;
- which bad configurations are refused;
- that a blocked `preq`, or a write made while busy, changes nothing visible at the ports.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    function automatic logic [2:0] size_bytes(input size_e sz);
        case (sz)
            SZ_WORD: size_bytes = 3'd4;
            SZ_HALF: size_bytes = 3'd2;
            SZ_BYTE: size_bytes = 3'd1;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_ch_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int CH_ID = 0
) (
    input  size_e           src_size,
    input  size_e           dst_size,
    input  logic [AW-1:0]   src_addr,
    input  logic [AW-1:0]   dst_addr,
    input  logic [CW-1:0]   count,
    input  logic [1:0]      link_sel,
    output logic            cfg_err,
    output size_e           xfer_size,
    output logic [2:0]      xfer_bytes,
    output logic [2:0]      src_step,
    output logic [2:0]      dst_step
);

    logic src_ok, dst_ok, cnt_ok;

    function automatic logic is_aligned(input logic [1:0] lo, input size_e sz);
        case (sz)
            SZ_WORD: is_aligned = (lo == 2'b00);
            SZ_HALF: is_aligned = !lo[0];
            SZ_BYTE: is_aligned = 1'b1;
            default: is_aligned = 1'b0;
        endcase
    endfunction

    always_comb begin
        src_step   = size_bytes(src_size);
        dst_step   = size_bytes(dst_size);
        xfer_size  = (src_step >= dst_step) ? src_size : dst_size;
        xfer_bytes = (src_step >= dst_step) ? src_step : dst_step;
        src_ok     = is_aligned(src_addr[1:0], src_size);
        dst_ok     = is_aligned(dst_addr[1:0], dst_size);
        cnt_ok     = (count != '0) &&
                     ((count & CW'(xfer_bytes - 3'd1)) == '0);
        cfg_err    = !src_ok || !dst_ok || !cnt_ok ||
                     (link_sel == 2'(CH_ID));
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic          inc_i,
    input  logic [2:0]    step_i,
    output logic [AW-1:0] addr_o
);

    always_comb begin
        addr_o = inc_i ? (addr_i + AW'(step_i)) : addr_i;
    end

endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
    import dma_ch_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int CH_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ctl_go,
    input  logic          ctl_hw_en,
    input  logic [1:0]    ctl_src_size,
    input  logic [1:0]    ctl_dst_size,
    input  logic          ctl_src_inc,
    input  logic          ctl_dst_inc,
    input  logic          ctl_burst,
    input  logic          ctl_irq_en,
    input  logic [1:0]    ctl_link,
    input  logic          src_we,
    input  logic [AW-1:0] src_wdata,
    input  logic          dst_we,
    input  logic [AW-1:0] dst_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          clr_status,
    input  logic          preq,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          go_out,
    output logic          hw_en_out,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out,
    output logic          stat_done,
    output logic          stat_busy,
    output logic          stat_cerr,
    output logic          irq
);

    localparam int NSIDE = 2;

    typedef struct packed {
        state_e        state;
        logic          go;
        logic          hw_en;
        logic          src_inc;
        logic          dst_inc;
        logic          burst;
        logic          irq_en;
        size_e         src_size;
        size_e         dst_size;
        logic [1:0]    link;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          done;
        logic          busy;
        logic          cerr;
    } regs_t;

    regs_t q, d;

    logic          cfg_err;
    size_e         xfer_size;
    logic [2:0]    xfer_bytes;
    logic [2:0]    src_step, dst_step;
    logic          req;
    logic [CW-1:0] cnt_next;

    logic [AW-1:0] base_a [NSIDE];
    logic          inc_a  [NSIDE];
    logic [2:0]    step_a [NSIDE];
    logic [AW-1:0] next_a [NSIDE];

    dma_cfg_check #(.AW(AW), .CW(CW), .CH_ID(CH_ID)) u_check (
        .src_size   (q.src_size),
        .dst_size   (q.dst_size),
        .src_addr   (q.src),
        .dst_addr   (q.dst),
        .count      (q.cnt),
        .link_sel   (q.link),
        .cfg_err    (cfg_err),
        .xfer_size  (xfer_size),
        .xfer_bytes (xfer_bytes),
        .src_step   (src_step),
        .dst_step   (dst_step)
    );

    assign base_a[0] = q.src;
    assign inc_a[0]  = q.src_inc;
    assign step_a[0] = src_step;
    assign base_a[1] = q.dst;
    assign inc_a[1]  = q.dst_inc;
    assign step_a[1] = dst_step;

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_step
            dma_addr_step #(.AW(AW)) u_step (
                .addr_i (base_a[s]),
                .inc_i  (inc_a[s]),
                .step_i (step_a[s]),
                .addr_o (next_a[s])
            );
        end
    endgenerate

    always_comb begin
        d         = q;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = q.src;
        bus_size  = xfer_size;
        bus_wdata = q.data;
        req       = q.go || (q.hw_en && preq);
        cnt_next  = q.cnt - CW'(xfer_bytes);

        if (clr_status) begin
            d.done = 1'b0;
            d.cerr = 1'b0;
        end

        case (q.state)
            ST_IDLE: begin
                if (req) begin
                    d.go = 1'b0;
                    if (cfg_err) begin
                        d.cerr = 1'b1;
                    end else begin
                        d.busy  = 1'b1;
                        d.state = ST_READ;
                    end
                end else begin
                    if (ctl_we) begin
                        d.go       = ctl_go;
                        d.hw_en    = ctl_hw_en;
                        d.src_size = size_e'(ctl_src_size);
                        d.dst_size = size_e'(ctl_dst_size);
                        d.src_inc  = ctl_src_inc;
                        d.dst_inc  = ctl_dst_inc;
                        d.burst    = ctl_burst;
                        d.irq_en   = ctl_irq_en;
                        d.link     = ctl_link;
                    end
                    if (src_we) d.src = src_wdata;
                    if (dst_we) d.dst = dst_wdata;
                    if (cnt_we) d.cnt = cnt_wdata;
                end
            end
            ST_READ: begin
                bus_valid = 1'b1;
                bus_addr  = q.src;
                if (bus_ready) begin
                    d.data  = bus_rdata;
                    d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = q.dst;
                if (bus_ready) begin
                    d.src = next_a[0];
                    d.dst = next_a[1];
                    d.cnt = cnt_next;
                    if (cnt_next == '0) begin
                        d.done  = 1'b1;
                        d.busy  = 1'b0;
                        d.hw_en = 1'b0;
                        d.state = ST_IDLE;
                    end else if (q.burst) begin
                        d.state = ST_READ;
                    end else begin
                        d.busy  = 1'b0;
                        d.state = ST_IDLE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign go_out    = q.go;
    assign hw_en_out = q.hw_en;
    assign src_out   = q.src;
    assign dst_out   = q.dst;
    assign cnt_out   = q.cnt;
    assign stat_done = q.done;
    assign stat_busy = q.busy;
    assign stat_cerr = q.cerr;
    assign irq       = q.irq_en && (q.done || q.cerr);

    p_go_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !q.go);

    p_err_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cerr) |-> !bus_valid);

    p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_write)));

    p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_ready) |=> (bus_valid && bus_write));

    p_done_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> (q.cnt == '0 && !q.busy && !q.hw_en));

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |->
            ($stable(q.src_size) && $stable(q.dst_size) && $stable(q.burst)));

endmodule

// File: tb/dma_xfer_channel_bench.sv
module dma_xfer_channel_bench;

    localparam int AW = 32;
    localparam int CW = 16;
    localparam int NV = 10;

    // {ssize, dsize, sinc, dinc, burst, link, src, dst, cnt, expect_err}
    localparam logic [33:0] VEC [NV] = '{
        {2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'd1, 8'h04, 8'h80, 8'd12, 1'b0},
        {2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 2'd1, 8'h05, 8'h91, 8'd4,  1'b0},
        {2'b10, 2'b00, 1'b1, 1'b1, 1'b1, 2'd2, 8'h02, 8'h84, 8'd8,  1'b0},
        {2'b01, 2'b10, 1'b1, 1'b0, 1'b1, 2'd3, 8'h10, 8'hA0, 8'd6,  1'b0},
        {2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'd1, 8'h06, 8'h80, 8'd4,  1'b1},
        {2'b01, 2'b10, 1'b1, 1'b1, 1'b1, 2'd1, 8'h00, 8'h81, 8'd2,  1'b1},
        {2'b11, 2'b01, 1'b1, 1'b1, 1'b1, 2'd1, 8'h00, 8'h80, 8'd4,  1'b1},
        {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 2'd0, 8'h00, 8'h80, 8'd4,  1'b1},
        {2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'd1, 8'h00, 8'h80, 8'd6,  1'b1},
        {2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 2'd1, 8'h00, 8'h80, 8'd0,  1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          ctl_we = 0, ctl_go = 0, ctl_hw_en = 0;
    logic [1:0]    ctl_src_size = 0, ctl_dst_size = 0, ctl_link = 0;
    logic          ctl_src_inc = 0, ctl_dst_inc = 0, ctl_burst = 0, ctl_irq_en = 0;
    logic          src_we = 0, dst_we = 0, cnt_we = 0, clr_status = 0, preq = 0;
    logic [AW-1:0] src_wdata = 0, dst_wdata = 0;
    logic [CW-1:0] cnt_wdata = 0;
    logic          bus_valid, bus_write, bus_ready;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          go_out, hw_en_out, stat_done, stat_busy, stat_cerr, irq;
    logic [AW-1:0] src_out, dst_out;
    logic [CW-1:0] cnt_out;

    logic          ready_en = 1'b1;
    logic          fill_req = 1'b0;
    logic [7:0]    mem [256];
    int            nbus = 0;
    int            checks = 0;
    int            errors = 0;
    bit            timed_out = 0;

    assign bus_ready = ready_en;

    dma_xfer_channel #(.AW(AW), .CW(CW), .CH_ID(0)) u_dma_xfer_channel (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_go(ctl_go), .ctl_hw_en(ctl_hw_en),
        .ctl_src_size(ctl_src_size), .ctl_dst_size(ctl_dst_size),
        .ctl_src_inc(ctl_src_inc), .ctl_dst_inc(ctl_dst_inc),
        .ctl_burst(ctl_burst), .ctl_irq_en(ctl_irq_en), .ctl_link(ctl_link),
        .src_we(src_we), .src_wdata(src_wdata), .dst_we(dst_we), .dst_wdata(dst_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .clr_status(clr_status), .preq(preq),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .go_out(go_out), .hw_en_out(hw_en_out),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .stat_done(stat_done), .stat_busy(stat_busy), .stat_cerr(stat_cerr), .irq(irq)
    );

    function automatic int szb(input logic [1:0] c);
        case (c)
            2'b00:   szb = 4;
            2'b01:   szb = 1;
            2'b10:   szb = 2;
            default: szb = 0;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int a);
        pat = 8'(a * 7 + 3);
    endfunction

    always_comb begin
        bus_rdata = {mem[8'(bus_addr[7:0] + 8'd3)], mem[8'(bus_addr[7:0] + 8'd2)],
                     mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]};
    end

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= (i < 128) ? pat(i) : 8'h00;
        end else if (bus_valid && bus_write && bus_ready) begin
            for (int b = 0; b < 4; b++)
                if (b < szb(bus_size)) mem[8'(bus_addr[7:0] + 8'(b))] <= bus_wdata[8*b +: 8];
        end
        if (bus_valid && bus_ready) nbus <= nbus + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill_mem();
        @(negedge clk); fill_req = 1'b1;
        @(negedge clk); fill_req = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_status = 1'b1;
        @(negedge clk); clr_status = 1'b0;
    endtask

    task automatic prog(input logic [1:0] ss, input logic [1:0] ds, input logic si,
                        input logic di, input logic bm, input logic [1:0] lk,
                        input logic ie, input logic hw, input logic go,
                        input logic [7:0] sa, input logic [7:0] da, input logic [7:0] cb);
        @(negedge clk);
        src_we = 1; src_wdata = AW'(sa);
        dst_we = 1; dst_wdata = AW'(da);
        cnt_we = 1; cnt_wdata = CW'(cb);
        @(negedge clk);
        src_we = 0; dst_we = 0; cnt_we = 0;
        ctl_we = 1; ctl_go = go; ctl_hw_en = hw; ctl_src_size = ss; ctl_dst_size = ds;
        ctl_src_inc = si; ctl_dst_inc = di; ctl_burst = bm; ctl_link = lk; ctl_irq_en = ie;
        @(negedge clk);
        ctl_we = 0; ctl_go = 0;
    endtask

    task automatic run_vectors();
        logic [1:0] ss, ds, lk;
        logic si, di, bm, ee;
        logic [7:0] sa, da, cb;
        int xb, n, k, sb0, db0, base;
        for (int v = 0; v < NV; v++) begin
            {ss, ds, si, di, bm, lk, sa, da, cb, ee} = VEC[v];
            fill_mem();
            base = nbus;
            prog(ss, ds, si, di, bm, lk, 1'b0, 1'b0, 1'b1, sa, da, cb);
            cyc(60);
            if (ee) begin
                chk("R3 error flag", stat_cerr, 1);
                chk("R3 no bus beats", nbus - base, 0);
                chk("R3 src unchanged", int'(src_out), int'(sa));
                chk("R3 busy stays low", stat_busy, 0);
            end else begin
                xb = (szb(ss) > szb(ds)) ? szb(ss) : szb(ds);
                n  = bm ? int'(cb) / xb : 1;
                chk("R8/R7 beat count", nbus - base, 2 * n);
                chk("R5 src end", int'(src_out), int'(sa) + (si ? n * szb(ss) : 0));
                chk("R5 dst end", int'(dst_out), int'(da) + (di ? n * szb(ds) : 0));
                chk("R6 count left", int'(cnt_out), int'(cb) - n * xb);
                chk("R6 done flag", stat_done, (int'(cb) == n * xb) ? 1 : 0);
                chk("R7 busy low", stat_busy, 0);
                chk("R3 no error", stat_cerr, 0);
                k   = n - 1;
                sb0 = int'(sa) + (si ? k * szb(ss) : 0);
                db0 = int'(da) + (di ? k * szb(ds) : 0);
                for (int b = 0; b < xb; b++)
                    chk("R4 data moved", mem[8'(db0 + b)], pat(sb0 + b));
            end
            chk("R11 irq off when disabled", irq, 0);
            clear_flags();
        end
    endtask

    task automatic run_directed();
        int base;
        // R2 / R4 / R10: stalled bus, writes while busy
        fill_mem();
        ready_en = 1'b0;
        prog(2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 8'h20, 8'hC0, 8'd8);
        chk("R2 go set before start", go_out, 1);
        chk("R2 not busy yet", stat_busy, 0);
        @(negedge clk);
        chk("R2 busy next edge", stat_busy, 1);
        chk("R2 go cleared", go_out, 0);
        chk("R4 read first", bus_write, 0);
        chk("R4 read address", int'(bus_addr), 32'h20);
        src_we = 1; src_wdata = 0; cnt_we = 1; cnt_wdata = 4;
        ctl_we = 1; ctl_src_size = 2'b01; ctl_burst = 1;
        @(negedge clk);
        src_we = 0; cnt_we = 0; ctl_we = 0; ctl_burst = 0; ctl_src_size = 0;
        chk("R4 held while stalled", int'(bus_addr), 32'h20);
        ready_en = 1'b1;
        cyc(20);
        chk("R10 src write ignored", int'(src_out), 32'h24);
        chk("R10 dst end", int'(dst_out), 32'hC4);
        chk("R10 count write ignored", int'(cnt_out), 4);
        chk("R7 one unit then idle", stat_busy, 0);
        for (int b = 0; b < 4; b++) chk("R4 stalled data", mem[8'(8'hC0 + b)], pat(32 + b));

        // R1: preq blocked, then enabled in continuous mode
        fill_mem();
        prog(2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h30, 8'hD0, 8'd4);
        base = nbus;
        preq = 1'b1; cyc(5); preq = 1'b0;
        cyc(5);
        chk("R1 preq ignored busy", stat_busy, 0);
        chk("R1 preq ignored beats", nbus - base, 0);
        chk("R1 preq ignored count", int'(cnt_out), 4);
        prog(2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 8'h30, 8'hD0, 8'd4);
        chk("R1 enable stored", hw_en_out, 1);
        @(negedge clk); preq = 1'b1;
        @(negedge clk); preq = 1'b0;
        cyc(20);
        chk("R1 preq started run", stat_done, 1);
        chk("R6 enable cleared", hw_en_out, 0);
        chk("R6 count zero", int'(cnt_out), 0);
        chk("R5 src after preq", int'(src_out), 32'h34);
        clear_flags();
        chk("R9 done cleared", stat_done, 0);

        // R7: cycle-steal, two peripheral pulses
        fill_mem();
        prog(2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 8'h08, 8'hE0, 8'd2);
        @(negedge clk); preq = 1'b1;
        @(negedge clk); preq = 1'b0;
        cyc(10);
        chk("R7 one byte per request", int'(cnt_out), 1);
        chk("R7 idle between requests", stat_busy, 0);
        chk("R7 enable kept", hw_en_out, 1);
        @(negedge clk); preq = 1'b1;
        @(negedge clk); preq = 1'b0;
        cyc(10);
        chk("R7 second request", int'(cnt_out), 0);
        chk("R6 done after last", stat_done, 1);
        chk("R7 second byte", mem[8'hE1], pat(9));
        chk("R11 irq off ie=0 with done", irq, 0);
        clear_flags();

        // R11 / R9: error with interrupt enabled
        prog(2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h80, 8'd4);
        cyc(3);
        chk("R3 link equals own channel", stat_cerr, 1);
        chk("R11 irq on error", irq, 1);
        clear_flags();
        chk("R9 error cleared", stat_cerr, 0);
        chk("R11 irq drops", irq, 0);
    endtask

    task automatic run_all();
        cyc(3);
        chk("R6 reset busy", stat_busy, 0);
        chk("R6 reset done", stat_done, 0);
        chk("R3 reset error", stat_cerr, 0);
        chk("R4 reset bus idle", bus_valid, 0);
        chk("R6 reset count", int'(cnt_out), 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(2);
        run_vectors();
        run_directed();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule